// File: doc/BRIEF.md
# PMBus Command Write-Protection Filter

This block decides, for every command write arriving from the bus decoder of a digital power controller, whether the target register may be updated. It holds a 16-bit extended lock register in which most bits each guard a fixed group of command codes. It combines those group locks with the standard write-protect level supplied by the register file. For each write strobe it raises exactly one of two one-cycle outputs: a write enable toward the register file, or a reject pulse toward the communication-error status logic.

Three lock bits behave specially. The master lock is self-sealing: once it is 1, no bus write and no restore can clear it. The store lock acts only through a shadow copy that is captured at reset and at every restore, so a change written over the bus has no effect until a store and a later reset or restore. The restore lock blocks only bus restore commands and leaves the automatic restore event untouched. The lock register reads back on a parallel port. Restores reload it from the non-volatile image presented on the default input.

Top module: `pmbus_wp_filter`

## Requirements
- R1: While `rstN` is low, the lock register loads `nvmDefault` at each clock edge with bit 15 forced to 0, and `wrEnable` and `rejectPulse` are 0.
- R2: A write strobe sampled at a rising edge produces, during the following cycle only, exactly one of `wrEnable` (accepted) or `rejectPulse` (rejected). With no strobe, both outputs are 0 in the next cycle.
- R3: Bit 15 of `lockRdData` always reads 0. A write of 1 to it is ignored.
- R4: When bit 14 (master lock) is 1, writes to codes 10h and DDh are rejected. Once bit 14 is 1, neither a write nor `restoreEvt` returns it to 0. Only a reset load can clear it.
- R5: Group locks reject writes when set. Bit 13 guards 22h, 29h, 2Ah, A4h and D5h. Bit 12 guards 20h and 21h. Bit 11 guards 24h, 2Bh, 40h, 41h, 44h and 45h. Bit 10 guards 1Bh, 42h, 43h, 4Ah and 51h. Bit 9 guards 46h, 47h, 4Fh and 50h. Bit 8 guards 25h, 26h and 27h. Bit 7 guards 01h. Bit 6 guards 33h, D1h, D2h, D4h and D6h. Bit 5 guards 55h. Bit 4 guards 02h, 35h, 36h, 60h, 61h, 64h and 65h. Bit 3 guards 99h, 9Ah and 9Bh. Bit 2 guards 0Eh. Bit 1 guards 16h.
- R6: A write to 15h is rejected only when the store-lock shadow is 1. The shadow takes `nvmDefault[0]` at reset and on `restoreEvt`. A bus write to bit 0 changes the readback but not the shadow.
- R7: The write-protect level `wpLevel` works as follows. 00h blocks nothing. 20h blocks every code except 10h, 01h, 02h and 21h. 40h blocks every code except 10h and 01h. 80h blocks every code except 10h. Any other value behaves as 80h.
- R8: A write is rejected if the write-protect level blocks it or its guarding lock bit is active. A code whose guarding bit is 0, or that has no guarding bit, is decided by the write-protect level alone.
- R9: An accepted write to DDh loads `wrData` into the lock register at the strobe edge (bit 14 ORed with its old value). The new value is visible on `lockRdData` in the next cycle and governs the next write.
- R10: A `restoreEvt` pulse reloads the lock register from `nvmDefault` (bit 15 forced to 0, bit 14 kept if already set). It acts regardless of bit 1, and it takes priority over a simultaneous write to DDh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| nvmDefault | input | 16 | Non-volatile lock image loaded at reset and restore |
| wpLevel | input | 8 | Standard write-protect level |
| wrStrobe | input | 1 | One-cycle write request from the command decoder |
| cmdCode | input | 8 | Command code of the write |
| wrData | input | 16 | Write data (used for code DDh) |
| restoreEvt | input | 1 | Restore performed (power-up or accepted restore command) |
| wrEnable | output | 1 | Registered write enable toward the register file |
| rejectPulse | output | 1 | Registered reject pulse toward status logic |
| lockRdData | output | 16 | Current lock register value |

## Verification
Both decision outputs are registered. A strobe driven before edge k is therefore judged in the cycle after edge k. The bench drives on falling edges and samples at the next falling edge. The lock register updates at that same edge k, so `lockRdData` is compared in the same sample as the decision. One idle cycle follows each write, and in it both outputs are checked to be low. The store-lock shadow has no port of its own. Its delay is checked through the decision on the next 15h write, which is issued after a bus change to bit 0 and again after a restore pulse.

// File: rtl/wpf_pkg.sv
package wpf_pkg;
  localparam int CMD_W      = 8;
  localparam int LOCK_W     = 16;
  localparam int UNUSED_BIT = 15;
  localparam int MASTER_BIT = 14;
  localparam int STORE_BIT  = 0;

  localparam logic [CMD_W-1:0] CMD_WP     = 8'h10;
  localparam logic [CMD_W-1:0] CMD_XLOCK  = 8'hDD;
  localparam logic [CMD_W-1:0] CMD_OPER   = 8'h01;
  localparam logic [CMD_W-1:0] CMD_ONOFF  = 8'h02;
  localparam logic [CMD_W-1:0] CMD_VSET   = 8'h21;

  typedef enum logic [1:0] {
    WP_OPEN    = 2'd0,
    WP_SETONLY = 2'd1,
    WP_OPONLY  = 2'd2,
    WP_FULL    = 2'd3
  } wpMode_e;

  typedef struct packed {
    logic lockWr;
    logic reload;
  } wpfStrobe_t;

  function automatic wpMode_e decodeWp(input logic [7:0] lvl);
    wpMode_e m;
    case (lvl)
      8'h00:   m = WP_OPEN;
      8'h20:   m = WP_SETONLY;
      8'h40:   m = WP_OPONLY;
      default: m = WP_FULL;
    endcase
    return m;
  endfunction

  function automatic logic wpBlocks(input wpMode_e m, input logic [CMD_W-1:0] cmd);
    logic blk;
    case (m)
      WP_OPEN:    blk = 1'b0;
      WP_SETONLY: blk = !(cmd == CMD_WP || cmd == CMD_OPER ||
                          cmd == CMD_ONOFF || cmd == CMD_VSET);
      WP_OPONLY:  blk = !(cmd == CMD_WP || cmd == CMD_OPER);
      default:    blk = (cmd != CMD_WP);
    endcase
    return blk;
  endfunction

  function automatic logic [LOCK_W-1:0] lockGuard(input logic [CMD_W-1:0] cmd);
    logic [LOCK_W-1:0] g;
    g = '0;
    case (cmd)
      8'h10, 8'hDD:                                    g[14] = 1'b1;
      8'h22, 8'h29, 8'h2A, 8'hA4, 8'hD5:               g[13] = 1'b1;
      8'h20, 8'h21:                                    g[12] = 1'b1;
      8'h24, 8'h2B, 8'h40, 8'h41, 8'h44, 8'h45:        g[11] = 1'b1;
      8'h1B, 8'h42, 8'h43, 8'h4A, 8'h51:               g[10] = 1'b1;
      8'h46, 8'h47, 8'h4F, 8'h50:                      g[9]  = 1'b1;
      8'h25, 8'h26, 8'h27:                             g[8]  = 1'b1;
      8'h01:                                           g[7]  = 1'b1;
      8'h33, 8'hD1, 8'hD2, 8'hD4, 8'hD6:               g[6]  = 1'b1;
      8'h55:                                           g[5]  = 1'b1;
      8'h02, 8'h35, 8'h36, 8'h60, 8'h61, 8'h64, 8'h65: g[4]  = 1'b1;
      8'h99, 8'h9A, 8'h9B:                             g[3]  = 1'b1;
      8'h0E:                                           g[2]  = 1'b1;
      8'h16:                                           g[1]  = 1'b1;
      8'h15:                                           g[0]  = 1'b1;
      default: ;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/wpf_datapath.sv
module wpf_datapath
  import wpf_pkg::*;
#(
  parameter int LW = LOCK_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [LW-1:0] nvmDefault,
  input  logic [LW-1:0] wrData,
  input  wpfStrobe_t    strobes,
  output logic [LW-1:0] lockValue,
  output logic [LW-1:0] effLock
);
  logic [LW-1:0] lockReg;
  logic          storeShadow;

  for (genvar i = 0; i < LW; i++) begin : gBit
    if (i == UNUSED_BIT) begin : gUnused
      always_ff @(posedge clk) lockReg[i] <= 1'b0;
    end else if (i == MASTER_BIT) begin : gSticky
      always_ff @(posedge clk) begin
        if (!rstN)               lockReg[i] <= nvmDefault[i];
        else if (strobes.reload) lockReg[i] <= lockReg[i] | nvmDefault[i];
        else if (strobes.lockWr) lockReg[i] <= lockReg[i] | wrData[i];
      end
    end else begin : gPlain
      always_ff @(posedge clk) begin
        if (!rstN)               lockReg[i] <= nvmDefault[i];
        else if (strobes.reload) lockReg[i] <= nvmDefault[i];
        else if (strobes.lockWr) lockReg[i] <= wrData[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.reload) storeShadow <= nvmDefault[STORE_BIT];
  end

  always_comb begin
    lockValue = lockReg;
    effLock   = lockReg;
    effLock[STORE_BIT] = storeShadow;
  end
endmodule

// File: rtl/wpf_ctrl.sv
module wpf_ctrl
  import wpf_pkg::*;
#(
  parameter int LW = LOCK_W,
  parameter int CW = CMD_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrStrobe,
  input  logic [CW-1:0] cmdCode,
  input  logic [7:0]    wpLevel,
  input  logic          restoreEvt,
  input  logic [LW-1:0] effLock,
  output wpfStrobe_t    strobes,
  output logic          wrEnable,
  output logic          rejectPulse
);
  logic [LW-1:0] guard;
  logic [LW-1:0] hit;
  logic          groupBlock;
  logic          levelBlock;
  logic          reject;

  assign guard = lockGuard(cmdCode);

  for (genvar i = 0; i < LW; i++) begin : gHit
    assign hit[i] = guard[i] & effLock[i];
  end

  assign groupBlock = |hit;
  assign levelBlock = wpBlocks(decodeWp(wpLevel), cmdCode);
  assign reject     = groupBlock | levelBlock;

  always_comb begin
    strobes.reload = restoreEvt;
    strobes.lockWr = wrStrobe && (cmdCode == CMD_XLOCK) && !reject;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrEnable    <= 1'b0;
      rejectPulse <= 1'b0;
    end else begin
      wrEnable    <= wrStrobe & ~reject;
      rejectPulse <= wrStrobe & reject;
    end
  end
endmodule

// File: rtl/pmbus_wp_filter.sv
module pmbus_wp_filter
  import wpf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [LOCK_W-1:0] nvmDefault,
  input  logic [7:0]        wpLevel,
  input  logic              wrStrobe,
  input  logic [CMD_W-1:0]  cmdCode,
  input  logic [LOCK_W-1:0] wrData,
  input  logic              restoreEvt,
  output logic              wrEnable,
  output logic              rejectPulse,
  output logic [LOCK_W-1:0] lockRdData
);
  wpfStrobe_t        strobes;
  logic [LOCK_W-1:0] effLock;

  wpf_ctrl #(.LW(LOCK_W), .CW(CMD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .cmdCode(cmdCode),
    .wpLevel(wpLevel), .restoreEvt(restoreEvt), .effLock(effLock),
    .strobes(strobes), .wrEnable(wrEnable), .rejectPulse(rejectPulse)
  );

  wpf_datapath #(.LW(LOCK_W)) u_dp (
    .clk(clk), .rstN(rstN), .nvmDefault(nvmDefault), .wrData(wrData),
    .strobes(strobes), .lockValue(lockRdData), .effLock(effLock)
  );
endmodule

// File: rtl/wpf_checker.sv
module wpf_checker (
  input logic        clk,
  input logic        rstN,
  input logic        wrStrobe,
  input logic [7:0]  cmdCode,
  input logic        restoreEvt,
  input logic        wrEnable,
  input logic        rejectPulse,
  input logic [15:0] lockRdData
);
  assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> (wrEnable ^ rejectPulse));

  assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !wrStrobe |=> (!wrEnable && !rejectPulse));

  assert_unused_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    lockRdData[15] == 1'b0);

  assert_master_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    lockRdData[14] |=> lockRdData[14]);

  assert_master_blocks_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && (cmdCode == 8'hDD || cmdCode == 8'h10) && lockRdData[14]) |=> rejectPulse);

  assert_oper_lock_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && cmdCode == 8'h01 && lockRdData[7]) |=> rejectPulse);

  assert_lock_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!(wrStrobe && cmdCode == 8'hDD) && !restoreEvt) |=> $stable(lockRdData));
endmodule

bind pmbus_wp_filter wpf_checker u_chk (
  .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .cmdCode(cmdCode),
  .restoreEvt(restoreEvt), .wrEnable(wrEnable), .rejectPulse(rejectPulse),
  .lockRdData(lockRdData)
);

// File: tb/tb_pmbus_wp_filter.sv
module tb_pmbus_wp_filter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] nvmDefault = '0;
  logic [7:0]  wpLevel = '0;
  logic        wrStrobe = 1'b0;
  logic [7:0]  cmdCode = '0;
  logic [15:0] wrData = '0;
  logic        restoreEvt = 1'b0;
  logic        wrEnable, rejectPulse;
  logic [15:0] lockRdData;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] mLock;
  logic        mShadow;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmbus_wp_filter dut (
    .clk(clk), .rstN(rstN), .nvmDefault(nvmDefault), .wpLevel(wpLevel),
    .wrStrobe(wrStrobe), .cmdCode(cmdCode), .wrData(wrData),
    .restoreEvt(restoreEvt), .wrEnable(wrEnable), .rejectPulse(rejectPulse),
    .lockRdData(lockRdData)
  );

  function automatic int guardIdx(input logic [7:0] c);
    case (c)
      8'h10, 8'hDD: return 14;
      8'h22, 8'h29, 8'h2A, 8'hA4, 8'hD5: return 13;
      8'h20, 8'h21: return 12;
      8'h24, 8'h2B, 8'h40, 8'h41, 8'h44, 8'h45: return 11;
      8'h1B, 8'h42, 8'h43, 8'h4A, 8'h51: return 10;
      8'h46, 8'h47, 8'h4F, 8'h50: return 9;
      8'h25, 8'h26, 8'h27: return 8;
      8'h01: return 7;
      8'h33, 8'hD1, 8'hD2, 8'hD4, 8'hD6: return 6;
      8'h55: return 5;
      8'h02, 8'h35, 8'h36, 8'h60, 8'h61, 8'h64, 8'h65: return 4;
      8'h99, 8'h9A, 8'h9B: return 3;
      8'h0E: return 2;
      8'h16: return 1;
      8'h15: return 0;
      default: return -1;
    endcase
  endfunction

  function automatic bit levelBlocks(input logic [7:0] lvl, input logic [7:0] c);
    if (lvl == 8'h00) return 0;
    if (lvl == 8'h20) return !(c == 8'h10 || c == 8'h01 || c == 8'h02 || c == 8'h21);
    if (lvl == 8'h40) return !(c == 8'h10 || c == 8'h01);
    return c != 8'h10;
  endfunction

  function automatic bit expReject(input logic [7:0] lvl, input logic [7:0] c);
    int idx = guardIdx(c);
    bit grp = 0;
    if (idx == 0) grp = mShadow;
    else if (idx > 0) grp = mLock[idx];
    return levelBlocks(lvl, c) || grp;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic doReset(input logic [15:0] nvm);
    @(negedge clk);
    rstN = 1'b0; nvmDefault = nvm; wrStrobe = 1'b0; restoreEvt = 1'b0;
    repeat (2) @(negedge clk);
    mLock = nvm; mLock[15] = 1'b0; mShadow = nvm[0];
    chk(lockRdData == mLock, "R1 reset load", lockRdData, mLock);
    chk(!wrEnable && !rejectPulse, "R1 outputs idle in reset", {14'd0, wrEnable, rejectPulse}, 16'd0);
    rstN = 1'b1;
  endtask

  task automatic doWrite(input logic [7:0] c, input logic [15:0] d, input logic [7:0] lvl, input string req);
    bit rej;
    logic [15:0] nl;
    @(negedge clk);
    wrStrobe = 1'b1; cmdCode = c; wrData = d; wpLevel = lvl;
    rej = expReject(lvl, c);
    @(negedge clk);
    wrStrobe = 1'b0;
    chk(wrEnable == !rej && rejectPulse == rej, req, {14'd0, wrEnable, rejectPulse}, {14'd0, !rej, rej});
    if (c == 8'hDD && !rej) begin
      nl = d; nl[15] = 1'b0; nl[14] = mLock[14] | d[14];
      mLock = nl;
    end
    chk(lockRdData == mLock, "R9 lock readback", lockRdData, mLock);
    @(negedge clk);
    chk(!wrEnable && !rejectPulse, "R2 idle after pulse", {14'd0, wrEnable, rejectPulse}, 16'd0);
  endtask

  task automatic doRestore(input logic [15:0] nvm);
    logic [15:0] nl;
    @(negedge clk);
    nvmDefault = nvm; restoreEvt = 1'b1;
    @(negedge clk);
    restoreEvt = 1'b0;
    nl = nvm; nl[15] = 1'b0; nl[14] = mLock[14] | nvm[14];
    mLock = nl; mShadow = nvm[0];
    chk(lockRdData == mLock, "R10 restore reload", lockRdData, mLock);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  logic [7:0] repCode [14] = '{8'h15, 8'h16, 8'h0E, 8'h9A, 8'h60, 8'h55, 8'hD4,
                               8'h01, 8'h26, 8'h4F, 8'h42, 8'h2B, 8'h21, 8'hA4};
  logic [7:0] pool [20] = '{8'h10, 8'hDD, 8'h01, 8'h02, 8'h21, 8'h20, 8'h22, 8'h15,
                            8'h16, 8'h0E, 8'h99, 8'h36, 8'h55, 8'hD6, 8'h27, 8'h47,
                            8'h51, 8'h45, 8'hD5, 8'h03};
  logic [7:0] lvls [5] = '{8'h00, 8'h20, 8'h40, 8'h80, 8'h5A};

  initial begin
    void'($urandom(32'd20240611));
    // R1/R3: bit 15 forced low on reset load
    doReset(16'hFFFF);
    chk(lockRdData == 16'h7FFF, "R3 bit15 zero after reset", lockRdData, 16'h7FFF);

    doReset(16'h0000);
    doWrite(8'h01, 16'h0, 8'h00, "R8 open write accepted");
    doWrite(8'h7F, 16'h0, 8'h00, "R8 unguarded code accepted");
    // R6: bus write to bit 0 does not arm the store lock
    doWrite(8'hDD, 16'h0001, 8'h00, "R9 lock write accepted");
    doWrite(8'h15, 16'h0, 8'h00, "R6 store still allowed before reload");
    doWrite(8'hDD, 16'hFFFF, 8'h00, "R9 lock write all ones");
    chk(lockRdData == 16'h7FFF, "R3 bit15 ignores write", lockRdData, 16'h7FFF);
    doWrite(8'h10, 16'h0, 8'h00, "R4 wp command locked");
    doWrite(8'hDD, 16'h0000, 8'h00, "R4 lock register sealed");
    doWrite(8'h01, 16'h0, 8'h00, "R5 operation locked");
    doWrite(8'h15, 16'h0, 8'h00, "R6 store allowed, shadow still 0");
    doRestore(16'h0001);
    chk(lockRdData[14], "R4 master survives restore", lockRdData, 16'h4001);
    doWrite(8'h15, 16'h0, 8'h00, "R6 store blocked after restore");
    doWrite(8'h16, 16'h0, 8'h00, "R10 restore command open with bit1 clear");
    doRestore(16'h0002);
    doWrite(8'h16, 16'h0, 8'h00, "R5 restore command locked by bit1");
    doRestore(16'h0000);
    chk(lockRdData == 16'h4000, "R10 restore not gated by bit1", lockRdData, 16'h4000);

    // R7: write-protect levels
    doReset(16'h0000);
    doWrite(8'h01, 16'h0, 8'h80, "R7 level 80 blocks 01");
    doWrite(8'h10, 16'h0, 8'h80, "R7 level 80 allows 10");
    doWrite(8'h21, 16'h0, 8'h80, "R7 level 80 blocks 21");
    doWrite(8'h01, 16'h0, 8'h40, "R7 level 40 allows 01");
    doWrite(8'h02, 16'h0, 8'h40, "R7 level 40 blocks 02");
    doWrite(8'h02, 16'h0, 8'h20, "R7 level 20 allows 02");
    doWrite(8'h21, 16'h0, 8'h20, "R7 level 20 allows 21");
    doWrite(8'h20, 16'h0, 8'h20, "R7 level 20 blocks 20");
    doWrite(8'hDD, 16'h00FF, 8'h20, "R7 level 20 blocks lock write");
    doWrite(8'h33, 16'h0, 8'h5A, "R7 unlisted level acts as 80");
    doWrite(8'h10, 16'h0, 8'h5A, "R7 unlisted level allows 10");

    // R5: each group bit alone
    for (int b = 0; b < 14; b++) begin
      doReset(16'h1 << b);
      doWrite(repCode[b], 16'h0, 8'h00, "R5 group bit blocks its code");
      doWrite(repCode[(b + 1) % 14], 16'h0, 8'h00, "R8 other group unaffected");
    end

    // Random mix
    doReset(16'h0000);
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 99);
      logic [7:0] c;
      logic [15:0] d;
      if (n % 500 == 499) begin
        d = 16'($urandom);
        if ($urandom_range(0, 3) != 0) d[14] = 1'b0;
        doReset(d);
      end else if (r < 4) begin
        d = 16'($urandom);
        if ($urandom_range(0, 3) != 0) d[14] = 1'b0;
        doRestore(d);
      end else begin
        c = (r < 80) ? pool[$urandom_range(0, 19)] : 8'($urandom);
        d = 16'($urandom);
        if ($urandom_range(0, 7) != 0) d[14] = 1'b0;
        doWrite(c, d, lvls[$urandom_range(0, 4)], "R8 random write decision");
      end
    end
    finishRun();
  end
endmodule